// File: doc/BRIEF.md
# Stoppable Adaptive Local Clock Generator

This block produces the local clock for one locally synchronous island. It is modelled cycle by cycle on a fast reference tick: each local period is a count of reference ticks. The local clock is high for a programmable number of ticks and then low for another programmable number. Two strobes mark points inside the period. The first closes the shadow storage stage after the speculation delay. The second samples the island's error flag.

When the sampled error flag is set, the following period is stretched by a programmable extension. The extra time lets corrected data settle. While the metastability flag is high, the generator is frozen on the tick it has reached. It emits no strobes, holds the clock level and resumes from the same point once the flag drops.

An outside speculation controller can load a new timing set at any time. The set is checked, held pending, and swapped in only at a period boundary. Two counters report completed periods and stretched periods. From these a controller derives the error rate and the effective period.

Top module: `stop_clk_gen`

## Requirements
- R1: While reset is asserted, the local clock is high, both strobes and the reject flag are low, and both counters read zero.
- R2: With no error and no freeze, a period lasts high+low reference ticks, and the local clock is high for the first `high` ticks of it (tick offsets 0 to high-1 after the rise).
- R3: The shadow-close strobe is high for exactly one tick per period, at offset `spec` after the rising edge of the local clock.
- R4: The error-sample strobe is high for exactly one tick per period, at offset `samp`. The error input value at that tick decides whether the next period is stretched.
- R5: A period following a sampled error lasts high+low+ext ticks, with the extension added to the low part. The error counter increments once per stretched period, and the next error-free sample restores the nominal length.
- R6: An error input that is high at any tick other than the sampling tick has no effect on period length or the error counter.
- R7: While the meta input is high, the generator does not advance: the clock level holds and both strobes stay low. Once meta falls, the period completes with its remaining ticks, so a freeze lengthens it by exactly the frozen tick count.
- R8: A load is rejected, with a one-tick reject pulse on the tick after the load, when high, low, spec or ext is zero, when samp >= high, when spec > SPEC_MAX, or when spec >= high+low. A rejected load leaves the timing unchanged.
- R9: An accepted load does not alter the period in progress. It governs every period from the next rising edge onward.
- R10: The cycle counter increments by one at every period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| meta | input | 1 | Metastability flag; high freezes the generator |
| err | input | 1 | Speculation error flag, sampled at the error-sample tick |
| cfg_ld | input | 1 | One-tick load strobe for a new timing set |
| cfg_high | input | DLY_W | Ticks the local clock stays high |
| cfg_low | input | DLY_W | Ticks the local clock stays low in a nominal period |
| cfg_spec | input | DLY_W | Offset of the shadow-close strobe after the rise |
| cfg_ext | input | DLY_W | Extra low ticks in a stretched period |
| cfg_samp | input | DLY_W | Offset of the error-sample strobe after the rise |
| lclk | output | 1 | Local clock |
| shadow_close | output | 1 | Shadow-stage close strobe |
| err_sample | output | 1 | Error-sample strobe |
| cfg_reject | output | 1 | Pulse: last load was illegal |
| cyc_count | output | CNT_W | Completed periods |
| err_count | output | CNT_W | Stretched periods |

## Verification
A wrong tick position inside the period shows up within one local period. It appears as a strobe at the wrong offset from the rise, or as a high or low phase of the wrong length. A stretch decision latched at the wrong moment shows up one period late, as a period of the wrong length and a counter that disagrees with the errors injected. A freeze that leaks shows up as a strobe while meta is high or as a wrong count of ticks to the next rise. A configuration swapped mid-period shows up in the very period that carried the load.

// File: rtl/scg_pkg.sv
package scg_pkg;
  parameter int unsigned DLY_W = 8;
  parameter int unsigned PER_W = DLY_W + 2;

  typedef logic [DLY_W-1:0] dly_t;
  typedef logic [PER_W-1:0] per_t;

  typedef struct packed {
    dly_t high;
    dly_t low;
    dly_t spec;
    dly_t ext;
    dly_t samp;
  } tcfg_t;

  function automatic per_t wid(input dly_t v);
    return PER_W'(v);
  endfunction
endpackage

// File: rtl/scg_cfg.sv
module scg_cfg
  import scg_pkg::*;
#(
  parameter int SPEC_MAX = 12,
  parameter int RST_HIGH = 4,
  parameter int RST_LOW  = 4,
  parameter int RST_SPEC = 6,
  parameter int RST_EXT  = 3,
  parameter int RST_SAMP = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_i,
  input  tcfg_t new_i,
  input  logic  bound_i,
  output tcfg_t act_o,
  output logic  rej_o
);
  localparam tcfg_t RST_CFG = '{
    high: DLY_W'(RST_HIGH), low: DLY_W'(RST_LOW), spec: DLY_W'(RST_SPEC),
    ext: DLY_W'(RST_EXT), samp: DLY_W'(RST_SAMP)};
  localparam per_t SPEC_LIM = PER_W'(SPEC_MAX);

  tcfg_t act_q, act_n, pend_q, pend_n;
  logic  pv_q, pv_n, rej_q, rej_n, ok;

  always_comb begin
    ok = (new_i.high != '0) && (new_i.low != '0) && (new_i.spec != '0) &&
         (new_i.ext != '0) && (new_i.samp < new_i.high) &&
         (wid(new_i.spec) <= SPEC_LIM) &&
         (wid(new_i.spec) < wid(new_i.high) + wid(new_i.low));
    act_n  = act_q;
    pend_n = pend_q;
    pv_n   = pv_q;
    if (bound_i && pv_q) begin
      act_n = pend_q;
      pv_n  = 1'b0;
    end
    if (ld_i && ok) begin
      pend_n = new_i;
      pv_n   = 1'b1;
    end
    rej_n = ld_i && !ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_CFG;
      pend_q <= RST_CFG;
      pv_q   <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      act_q  <= act_n;
      pend_q <= pend_n;
      pv_q   <= pv_n;
      rej_q  <= rej_n;
    end
  end

  assign act_o = act_q;
  assign rej_o = rej_q;

  a_r8_act_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.samp < act_q.high) && (act_q.low != '0) && (act_q.spec != '0) &&
    (act_q.ext != '0) && (wid(act_q.spec) <= SPEC_LIM));

  a_r9_swap_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_i |=> $stable(act_q));
endmodule

// File: rtl/scg_phase.sv
module scg_phase
  import scg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  meta_i,
  input  logic  err_i,
  input  tcfg_t act_i,
  output logic  lclk_o,
  output logic  shc_o,
  output logic  esmp_o,
  output logic  bound_o,
  output logic  eq_o
);
  per_t ph_q, ph_n, plen;
  logic str_q, str_n, eq_q, eq_n;
  logic run, last;

  always_comb begin
    run  = !meta_i;
    plen = wid(act_i.high) + wid(act_i.low) + (str_q ? wid(act_i.ext) : '0);
    last = (ph_q == plen - per_t'(1));
    ph_n = ph_q;
    if (run) ph_n = last ? '0 : ph_q + per_t'(1);
    eq_n = eq_q;
    if (run && (ph_q == wid(act_i.samp))) eq_n = err_i;
    str_n = str_q;
    if (run && last) str_n = eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      str_q <= 1'b0;
      eq_q  <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      str_q <= str_n;
      eq_q  <= eq_n;
    end
  end

  assign lclk_o  = ph_q < wid(act_i.high);
  assign shc_o   = run && (ph_q == wid(act_i.spec));
  assign esmp_o  = run && (ph_q == wid(act_i.samp));
  assign bound_o = run && last;
  assign eq_o    = eq_q;

  a_r7_freeze_phase: assert property (@(posedge clk) disable iff (!rst_n)
    meta_i |=> $stable(ph_q));

  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < plen);

  a_r4_sample_only_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !esmp_o |=> $stable(eq_q));
endmodule

// File: rtl/scg_stats.sv
module scg_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bound_i,
  input  logic             eq_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] ecnt_o
);
  logic [CNT_W-1:0] cyc_q, cyc_n, ecnt_q, ecnt_n;

  always_comb begin
    cyc_n  = cyc_q;
    ecnt_n = ecnt_q;
    if (bound_i) begin
      cyc_n = cyc_q + CNT_W'(1);
      if (eq_i) ecnt_n = ecnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      ecnt_q <= '0;
    end else begin
      cyc_q  <= cyc_n;
      ecnt_q <= ecnt_n;
    end
  end

  assign cyc_o  = cyc_q;
  assign ecnt_o = ecnt_q;

  a_r10_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_i |=> $stable(cyc_q));

  a_r5_ecnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bound_i && eq_i) |=> $stable(ecnt_q));
endmodule

// File: rtl/stop_clk_gen.sv
module stop_clk_gen
  import scg_pkg::*;
#(
  parameter int SPEC_MAX = 12,
  parameter int CNT_W    = 16,
  parameter int RST_HIGH = 4,
  parameter int RST_LOW  = 4,
  parameter int RST_SPEC = 6,
  parameter int RST_EXT  = 3,
  parameter int RST_SAMP = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             meta,
  input  logic             err,
  input  logic             cfg_ld,
  input  logic [DLY_W-1:0] cfg_high,
  input  logic [DLY_W-1:0] cfg_low,
  input  logic [DLY_W-1:0] cfg_spec,
  input  logic [DLY_W-1:0] cfg_ext,
  input  logic [DLY_W-1:0] cfg_samp,
  output logic             lclk,
  output logic             shadow_close,
  output logic             err_sample,
  output logic             cfg_reject,
  output logic [CNT_W-1:0] cyc_count,
  output logic [CNT_W-1:0] err_count
);
  logic [1:0] rs_q;
  logic       rst_s;
  tcfg_t      new_cfg, act_cfg;
  logic       bound, eq;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign new_cfg = '{high: cfg_high, low: cfg_low, spec: cfg_spec,
                     ext: cfg_ext, samp: cfg_samp};

  scg_cfg #(
    .SPEC_MAX(SPEC_MAX), .RST_HIGH(RST_HIGH), .RST_LOW(RST_LOW),
    .RST_SPEC(RST_SPEC), .RST_EXT(RST_EXT), .RST_SAMP(RST_SAMP)
  ) u_cfg (
    .clk(clk_ref), .rst_n(rst_s), .ld_i(cfg_ld), .new_i(new_cfg),
    .bound_i(bound), .act_o(act_cfg), .rej_o(cfg_reject)
  );

  scg_phase u_phase (
    .clk(clk_ref), .rst_n(rst_s), .meta_i(meta), .err_i(err),
    .act_i(act_cfg), .lclk_o(lclk), .shc_o(shadow_close),
    .esmp_o(err_sample), .bound_o(bound), .eq_o(eq)
  );

  scg_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk_ref), .rst_n(rst_s), .bound_i(bound), .eq_i(eq),
    .cyc_o(cyc_count), .ecnt_o(err_count)
  );
endmodule

// File: tb/sim_stop_clk_gen.sv
module sim_stop_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       meta = 1'b0, err = 1'b0, cfg_ld = 1'b0;
  logic [7:0] c_high = 8'd0, c_low = 8'd0, c_spec = 8'd0, c_ext = 8'd0, c_samp = 8'd0;
  logic       lclk, shc, esmp, rej;
  logic [15:0] cyc, ecnt;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  stop_clk_gen u0 (
    .clk_ref(clk), .rst_n(rst_n), .meta(meta), .err(err), .cfg_ld(cfg_ld),
    .cfg_high(c_high), .cfg_low(c_low), .cfg_spec(c_spec), .cfg_ext(c_ext),
    .cfg_samp(c_samp), .lclk(lclk), .shadow_close(shc), .err_sample(esmp),
    .cfg_reject(rej), .cyc_count(cyc), .err_count(ecnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_rise();
    do @(negedge clk); while (lclk);
    do @(negedge clk); while (!lclk);
  endtask

  // starts and ends on a rise sample
  task automatic meas(output int per, output int hi, output int sc, output int es);
    logic pv;
    per = 0; hi = 0; sc = -1; es = -1;
    forever begin
      if (lclk) hi++;
      if (shc && sc < 0) sc = per;
      if (esmp && es < 0) es = per;
      pv = lclk;
      @(negedge clk);
      per++;
      if (lclk && !pv) break;
    end
  endtask

  task automatic load(input int h, input int l, input int s, input int x, input int m);
    c_high = 8'(h); c_low = 8'(l); c_spec = 8'(s); c_ext = 8'(x); c_samp = 8'(m);
    cfg_ld = 1'b1;
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 lclk", int'(lclk), 1);
    chk("R1 strobes", int'(shc | esmp), 0);
    chk("R1 reject", int'(rej), 0);
    chk("R1 cyc_count", int'(cyc), 0);
    chk("R1 err_count", int'(ecnt), 0);
  endtask

  task automatic t_nominal(input int h, input int l, input int s, input int m);
    int per, hi, sc, es, c0;
    to_rise();
    c0 = int'(cyc);
    meas(per, hi, sc, es);
    chk("R2 period", per, h + l);
    chk("R2 high ticks", hi, h);
    chk("R3 shadow offset", sc, s);
    chk("R4 sample offset", es, m);
    meas(per, hi, sc, es);
    chk("R10 cycle count", int'(cyc), c0 + 2);
  endtask

  task automatic t_stretch(input int h, input int l, input int x);
    int per, hi, sc, es, e0;
    to_rise();
    e0 = int'(ecnt);
    err = 1'b1;
    meas(per, hi, sc, es);
    err = 1'b0;
    chk("R5 period carrying error", per, h + l);
    meas(per, hi, sc, es);
    chk("R5 stretched period", per, h + l + x);
    chk("R5 stretched high", hi, h);
    chk("R5 error count", int'(ecnt), e0 + 1);
    meas(per, hi, sc, es);
    chk("R5 back to nominal", per, h + l);
  endtask

  task automatic t_window(input bit at_samp, input int m, input int exp_per, input string req);
    int n, per, hi, sc, es, e0;
    logic pv;
    to_rise();
    e0 = int'(ecnt);
    n = 0;
    forever begin
      err = at_samp ? (n == m) : (n != m);
      pv = lclk;
      @(negedge clk);
      n++;
      if (lclk && !pv) break;
    end
    err = 1'b0;
    meas(per, hi, sc, es);
    chk(req, per, exp_per);
    chk(req, int'(ecnt), e0 + (at_samp ? 1 : 0));
  endtask

  task automatic t_meta(input int h, input int l, input int s);
    int n, bad;
    logic pv;
    to_rise();
    repeat (s) @(negedge clk);
    meta = 1'b1;
    #1;
    chk("R7 strobe gated", int'(shc), 0);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (lclk != (s < h) || shc || esmp) bad++;
    end
    chk("R7 frozen outputs", bad, 0);
    meta = 1'b0;
    #1;
    chk("R7 resumes same tick", int'(shc), 1);
    n = 0;
    do begin
      pv = lclk;
      @(negedge clk);
      n++;
    end while (!(lclk && !pv));
    chk("R7 remaining ticks", n, h + l - s);
  endtask

  task automatic t_reject();
    int per, hi, sc, es;
    @(negedge clk);
    load(0, 4, 6, 3, 2);  chk("R8 zero high", int'(rej), 1);
    load(4, 4, 13, 3, 2); chk("R8 spec above max", int'(rej), 1);
    load(4, 4, 8, 3, 2);  chk("R8 spec past period", int'(rej), 1);
    load(4, 4, 6, 3, 4);  chk("R8 samp not below high", int'(rej), 1);
    load(4, 4, 6, 0, 2);  chk("R8 zero ext", int'(rej), 1);
    @(negedge clk);
    chk("R8 pulse ends", int'(rej), 0);
    to_rise();
    meas(per, hi, sc, es);
    chk("R8 timing unchanged", per, 8);
    chk("R8 spec unchanged", sc, 6);
  endtask

  task automatic t_load(input int h, input int l, input int s, input int x, input int m,
                        input int old_per);
    int n, per, hi, sc, es;
    logic pv;
    to_rise();
    @(negedge clk);
    load(h, l, s, x, m);
    chk("R9 accepted", int'(rej), 0);
    n = 2;
    do begin
      pv = lclk;
      @(negedge clk);
      n++;
    end while (!(lclk && !pv));
    chk("R9 current period kept", n, old_per);
    meas(per, hi, sc, es);
    chk("R9 new period", per, h + l);
    chk("R9 new high", hi, h);
    chk("R9 new shadow offset", sc, s);
    chk("R9 new sample offset", es, m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_nominal(4, 4, 6, 2);
    t_stretch(4, 4, 3);
    t_window(1'b1, 2, 11, "R4 error at sample tick");
    t_window(1'b0, 2, 8, "R6 error off sample tick");
    t_meta(4, 4, 6);
    t_reject();
    t_load(3, 5, 5, 2, 1, 8);
    t_stretch(3, 5, 2);
    t_load(2, 3, 4, 4, 1, 8);
    t_nominal(2, 3, 4, 1);
    t_stretch(2, 3, 4);
    t_meta(2, 3, 4);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule